// File: doc/BRIEF.md
# Swing-Mode Buffer Index Sequencer

This block keeps a small table of converter code words and a read pointer that chooses which word is driven out. A software trigger moves the pointer by one entry. The trigger is a write of one particular byte to a control register. The pointer's motion depends on the selected mode. In swing mode it climbs to the last entry and then descends to the first, and it keeps oscillating between the two ends. In wrap mode it returns to entry zero after the last entry. In one-time-scan mode it halts at the last entry.

Software can load the table through a plain write port. Software can also move the pointer directly through an index write. One-cycle pulses mark each arrival at the top entry and at the bottom entry, so a downstream sampler can frame each sweep. After reset the table holds an evenly stepped ramp, which by default is 100, 200, and so on up to 1000 over ten entries.

Top module: `swing_seq`

## Requirements
- R1: During and after reset the index equals START_IDX (default 0) and the direction is upward. Entry i holds INIT_BASE + i*INIT_STEP, which is 100..1000 by default. Both pulse flags are low.
- R2: `code_o` always shows the table entry selected by `idx_o`, in the same cycle in which the index or the entry changes.
- R3: A trigger is a cycle with `ctl_we_i` high and `ctl_data_i` equal to 8'hF0. Any other control byte, or no write at all, leaves the index unchanged.
- R4: With `mode_i` = 2'b01 (swing), each trigger moves the index by exactly one toward the current end. The end entries are not repeated: after DEPTH-1 comes DEPTH-2, and after 0 on the way down comes 1.
- R5: With `mode_i` = 2'b00 or 2'b11 (wrap), a trigger increments the index and moves it from DEPTH-1 back to 0. The direction is set upward.
- R6: With `mode_i` = 2'b10 (single scan), a trigger increments the index until it reaches DEPTH-1. Further triggers leave it there.
- R7: `top_o` is high for exactly the one cycle after a trigger has moved the index onto DEPTH-1. `bottom_o` is high for exactly the one cycle after a trigger has moved the index onto 0. Neither flag rises for a trigger that leaves the index in place, or for an index write.
- R8: An index write (`idx_we_i` with a value no greater than DEPTH-1) sets the index on the next edge and makes the direction upward. It takes priority over a trigger in the same cycle. A larger value is ignored, and a trigger in that cycle still acts.
- R9: `tbl_we_i` stores `tbl_data_i` into entry `tbl_addr_i` on the next edge. Addresses at or above DEPTH change no entry.
- R10: The index never exceeds DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00/11 wrap, 01 swing, 10 single scan |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_data_i | input | 8 | Control write data, 8'hF0 triggers a step |
| idx_we_i | input | 1 | Index register write strobe |
| idx_data_i | input | IDX_W (4) | New index value |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | IDX_W (4) | Table entry address |
| tbl_data_i | input | DATA_W (12) | Table entry value |
| code_o | output | DATA_W (12) | Selected code word |
| idx_o | output | IDX_W (4) | Current read index |
| top_o | output | 1 | One-cycle pulse: index reached the top entry |
| bottom_o | output | 1 | One-cycle pulse: index reached entry 0 |

## Verification
A trigger, an index write or a table write presented before a rising edge shows on `idx_o` and `code_o` right after that edge. The pulse flags are registered with the index, so they appear in that same cycle and must be low again one cycle later. The driver applies each stimulus at a falling edge and queues the outputs it predicts for after the next rising edge. The monitor samples one nanosecond after each rising edge and compares against the front of the queue, so every result is checked in the cycle it is due, including the drop of each flag.

// File: rtl/swing_seq_pkg.sv
package swing_seq_pkg;

  typedef enum logic [1:0] {
    MODE_WRAP   = 2'b00,
    MODE_SWING  = 2'b01,
    MODE_ONCE   = 2'b10,
    MODE_WRAP_B = 2'b11
  } seq_mode_e;

  localparam int CTL_W = 8;

endpackage

// File: rtl/swing_trig_dec.sv
module swing_trig_dec #(
  parameter int                           CTL_W     = 8,
  parameter logic [CTL_W-1:0]             TRIG_CODE = 8'hF0
) (
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_data,
  output logic             trig
);

  always_comb trig = ctl_we && (ctl_data == TRIG_CODE);

endmodule

// File: rtl/swing_table.sv
module swing_table #(
  parameter int DEPTH     = 10,
  parameter int DATA_W    = 12,
  parameter int INIT_BASE = 100,
  parameter int INIT_STEP = 100,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [DATA_W-1:0] INIT_V = DATA_W'(INIT_BASE + g * INIT_STEP);
    localparam logic [IDX_W-1:0]  MY_A   = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                    ent[g] <= INIT_V;
      else if (we && waddr == MY_A)  ent[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (raddr == IDX_W'(k)) rdata = ent[k];
    end
  end

endmodule

// File: rtl/swing_stepper.sv
module swing_stepper
  import swing_seq_pkg::*;
#(
  parameter int DEPTH     = 10,
  parameter int START_IDX = 0,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_mode_e        mode,
  input  logic             trig,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx,
  output logic             top_pulse,
  output logic             bot_pulse
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] START = IDX_W'(START_IDX);

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             up;
  } step_t;

  function automatic step_t calc_step(input logic [IDX_W-1:0] cur,
                                      input logic up,
                                      input seq_mode_e m);
    step_t r;
    r.idx = cur;
    r.up  = 1'b1;
    case (m)
      MODE_SWING: begin
        if (up) begin
          if (cur >= LIMIT) begin
            r.idx = LIMIT - 1'b1;
            r.up  = 1'b0;
          end else begin
            r.idx = cur + 1'b1;
            r.up  = (cur + 1'b1) != LIMIT;
          end
        end else begin
          if (cur == '0) begin
            r.idx = IDX_W'(1);
            r.up  = 1'b1;
          end else begin
            r.idx = cur - 1'b1;
            r.up  = (cur - 1'b1) == '0;
          end
        end
      end
      MODE_ONCE: r.idx = (cur >= LIMIT) ? LIMIT : cur + 1'b1;
      default:   r.idx = (cur >= LIMIT) ? '0 : cur + 1'b1;
    endcase
    return r;
  endfunction

  logic  dir_up;
  step_t nxt;
  logic  moved;

  always_comb begin
    nxt   = calc_step(idx, dir_up, mode);
    moved = trig && !load && (nxt.idx != idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= START;
      dir_up    <= 1'b1;
      top_pulse <= 1'b0;
      bot_pulse <= 1'b0;
    end else begin
      top_pulse <= moved && (nxt.idx == LIMIT);
      bot_pulse <= moved && (nxt.idx == '0);
      if (load) begin
        idx    <= load_val;
        dir_up <= 1'b1;
      end else if (trig) begin
        idx    <= nxt.idx;
        dir_up <= nxt.up;
      end
    end
  end

endmodule

// File: rtl/swing_seq.sv
module swing_seq
  import swing_seq_pkg::*;
#(
  parameter int                DEPTH     = 10,
  parameter int                DATA_W    = 12,
  parameter int                INIT_BASE = 100,
  parameter int                INIT_STEP = 100,
  parameter int                START_IDX = 0,
  parameter logic [CTL_W-1:0]  TRIG_CODE = 8'hF0,
  localparam int               IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_data_i,
  input  logic              idx_we_i,
  input  logic [IDX_W-1:0]  idx_data_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [DATA_W-1:0] tbl_data_i,
  output logic [DATA_W-1:0] code_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              top_o,
  output logic              bottom_o
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH - 1);

  seq_mode_e mode_sel;
  logic      trig_evt;
  logic      load_evt;

  always_comb begin
    mode_sel = seq_mode_e'(mode_i);
    load_evt = idx_we_i && (idx_data_i <= LIMIT);
  end

  swing_trig_dec #(.CTL_W(CTL_W), .TRIG_CODE(TRIG_CODE)) u_dec (
    .ctl_we   (ctl_we_i),
    .ctl_data (ctl_data_i),
    .trig     (trig_evt)
  );

  swing_stepper #(.DEPTH(DEPTH), .START_IDX(START_IDX)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_sel),
    .trig      (trig_evt),
    .load      (load_evt),
    .load_val  (idx_data_i),
    .idx       (idx_o),
    .top_pulse (top_o),
    .bot_pulse (bottom_o)
  );

  swing_table #(.DEPTH(DEPTH), .DATA_W(DATA_W),
                .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we_i),
    .waddr (tbl_addr_i),
    .wdata (tbl_data_i),
    .raddr (idx_o),
    .rdata (code_o)
  );

endmodule

// File: rtl/swing_seq_chk.sv
module swing_seq_chk #(
  parameter int  DEPTH  = 10,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             trig,
  input logic             load,
  input logic [IDX_W-1:0] load_val,
  input logic [IDX_W-1:0] idx,
  input logic             top,
  input logic             bot
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH - 1);

  a_r10_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LIMIT);

  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(top && bot));

  a_r7_top_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    top |-> idx == LIMIT);

  a_r7_bot_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bot |-> idx == '0);

  a_r7_top_single: assert property (@(posedge clk) disable iff (!rst_n)
    top |=> !top);

  a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !load) |=> $stable(idx));

  a_r4_swing_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !load && mode == 2'b01) |=>
      ((idx == $past(idx) + 1'b1) || ($past(idx) == idx + 1'b1)));

  a_r6_once_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !load && mode == 2'b10 && idx == LIMIT) |=> idx == LIMIT);

  a_r8_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(load_val)) && !top && !bot);

endmodule

bind swing_seq swing_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode_i),
  .trig     (trig_evt),
  .load     (load_evt),
  .load_val (idx_data_i),
  .idx      (idx_o),
  .top      (top_o),
  .bot      (bottom_o)
);

// File: tb/test_swing_seq.sv
module test_swing_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b01;
  logic        ctl_we_i = 1'b0;
  logic [7:0]  ctl_data_i = '0;
  logic        idx_we_i = 1'b0;
  logic [3:0]  idx_data_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_addr_i = '0;
  logic [11:0] tbl_data_i = '0;
  logic [11:0] code_o;
  logic [3:0]  idx_o;
  logic        top_o, bottom_o;

  always #2 clk = ~clk;

  swing_seq i_swing_seq (.*);

  int n_chk = 0, n_bad = 0;
  int m_tbl [10];
  int m_idx = 0;
  bit m_up = 1'b1;

  int    q_idx[$], q_code[$];
  bit    q_top[$], q_bot[$];
  string q_tag[$];

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares one nanosecond after each rising edge
  always @(posedge clk) begin
    #1;
    if (q_idx.size() > 0) begin
      int ei, ec; bit et, eb; string tg;
      ei = q_idx.pop_front(); ec = q_code.pop_front();
      et = q_top.pop_front(); eb = q_bot.pop_front(); tg = q_tag.pop_front();
      n_chk++;
      if (idx_o != ei || code_o != ec || top_o != et || bottom_o != eb) begin
        n_bad++;
        $display("FAIL %s actual idx=%0d code=%0d top=%0b bot=%0b expected idx=%0d code=%0d top=%0b bot=%0b",
                 tg, idx_o, code_o, top_o, bottom_o, ei, ec, et, eb);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the predicted outcome
  task automatic op(input logic cwe, input logic [7:0] cd, input logic iwe, input logic [3:0] id,
                    input logic twe, input logic [3:0] ta, input logic [11:0] td, input string tag);
    bit t = 0, b = 0;
    @(negedge clk);
    ctl_we_i = cwe; ctl_data_i = cd; idx_we_i = iwe; idx_data_i = id;
    tbl_we_i = twe; tbl_addr_i = ta; tbl_data_i = td;
    if (iwe && id <= 9) begin
      m_idx = id; m_up = 1'b1;
    end else if (cwe && cd == 8'hF0) begin
      int old = m_idx, nw;
      if (mode_i == 2'b01) begin
        if (m_up) begin
          if (old == 9) begin nw = 8; m_up = 1'b0; end else nw = old + 1;
        end else begin
          if (old == 0) begin nw = 1; m_up = 1'b1; end else nw = old - 1;
        end
        if (nw == 9) m_up = 1'b0;
        if (nw == 0) m_up = 1'b1;
      end else begin
        m_up = 1'b1;
        if (old < 9) nw = old + 1;
        else nw = (mode_i == 2'b10) ? 9 : 0;
      end
      t = (nw != old) && nw == 9;
      b = (nw != old) && nw == 0;
      m_idx = nw;
    end
    if (twe && ta < 10) m_tbl[ta] = td;
    q_idx.push_back(m_idx); q_code.push_back(m_tbl[m_idx]);
    q_top.push_back(t); q_bot.push_back(b); q_tag.push_back(tag);
  endtask

  task automatic trig(input string tag); op(1, 8'hF0, 0, 0, 0, 0, 0, tag); endtask
  task automatic idle(input string tag); op(0, 8'h00, 0, 0, 0, 0, 0, tag); endtask
  task automatic ldi(input logic [3:0] v, input string tag); op(0, 8'h00, 1, v, 0, 0, 0, tag); endtask

  task automatic drain;
    idle("idle");
    while (q_idx.size() > 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 10; i++) m_tbl[i] = 100 * (i + 1);
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", idx_o, 0, "reset idx");
    chk("R1", code_o, 100, "reset code");
    chk("R1", top_o, 0, "reset top");
    chk("R1", bottom_o, 0, "reset bottom");
    rst_n = 1'b1;
    idle("R1 after reset");
    // R1, R2, R8: walk every entry through the index register
    for (int i = 0; i < 10; i++) ldi(4'(i), "R2 R8 walk");
    ldi(0, "R8 back to 0");
    // R4, R7: two full swings
    mode_i = 2'b01;
    for (int i = 0; i < 36; i++) trig("R4 R7 swing");
    idle("R7 flag drop");
    // R3: non-trigger control bytes
    op(1, 8'h0F, 0, 0, 0, 0, 0, "R3 0x0F");
    op(1, 8'hF1, 0, 0, 0, 0, 0, "R3 0xF1");
    op(0, 8'hF0, 0, 0, 0, 0, 0, "R3 no strobe");
    // R5: wrap mode, both encodings
    mode_i = 2'b00;
    for (int i = 0; i < 12; i++) trig("R5 wrap");
    mode_i = 2'b11;
    for (int i = 0; i < 10; i++) trig("R5 wrap alt");
    // R6: single scan
    drain();
    mode_i = 2'b10;
    ldi(7, "R6 preset");
    for (int i = 0; i < 5; i++) trig("R6 scan");
    // R8: out of range ignored, priority over trigger
    drain();
    mode_i = 2'b01;
    ldi(4'd12, "R8 out of range");
    op(1, 8'hF0, 1, 4'd3, 0, 0, 0, "R8 load beats trigger");
    op(1, 8'hF0, 1, 4'd14, 0, 0, 0, "R8 bad load, trigger acts");
    // R8: load during descent turns direction upward
    ldi(9, "R8 to top");
    trig("R4 turn at top");
    trig("R4 down");
    ldi(3, "R8 mid-descent load");
    trig("R8 climbs after load");
    trig("R8 climbs after load");
    // R9: table writes
    op(0, 8'h00, 0, 0, 1, 4'd4, 12'hABC, "R9 write entry 4");
    op(0, 8'h00, 0, 0, 1, 4'd13, 12'h555, "R9 address 13 ignored");
    op(0, 8'h00, 0, 0, 1, 4'd5, 12'h123, "R2 R9 write current entry");
    for (int i = 0; i < 10; i++) ldi(4'(i), "R9 readback");
    drain();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule